// File: doc/BRIEF.md
# Two-Channel Serial SAR Converter Controller

This block is the digital controller of a 12-bit successive-approximation converter with two input channels. A host reads it over a three-wire serial port: an active-low select line, a serial clock and one data line. All ports are sampled on a single system clock, and the block finds the edges of the select line and the serial clock itself. The controller steers the input channel multiplexer and the track/hold switch. It produces the trial code for the capacitive DAC and reads back a one-bit comparator decision. It then frames the result as a 16-bit serial word.

A conversion starts when the select line goes low. The serial clock level at that moment picks the conversion clock. With the serial clock low, the host's serial clock drives the approximation steps. With it high, a free-running oscillator enable (`osc_tick`) drives them, and the host reads the result after the data line rises to flag completion. Each select cycle moves to the other channel. Taking the select line high powers the block down at once and discards any partial result.

Top module: `sar_adc_serial`

## Requirements
- R1: After reset, and in the cycle after any clock edge that samples `cs_n` high, the block is powered down: `pwr_down`=1, `dout_oe`=0, `dout`=0, `track`=0 and `sar_code`=0.
- R2: The `sclk` level sampled in the cycle where `cs_n` is first seen low sets the mode. Low selects host-clocked mode and high selects oscillator-clocked mode. In both modes `track` rises while selected, and `dout` is 0 until the first frame bit is driven.
- R3: In host-clocked mode `track` stays high through the first `sclk` falling edge and drops on the second. That edge samples the input and loads the trial code 0x800.
- R4: In oscillator-clocked mode the first `sclk` falling edge ends tracking. After that, exactly 12 `osc_tick` pulses make the 12 decisions, and `dout` stays 0 until the 12th pulse. It then goes to 1 as the completion flag, and further ticks have no effect.
- R5: The frame has 16 positions, MSB first. Positions 1 to 3 are 1, position 4 is the channel bit (0 for channel 0, 1 for channel 1), and positions 5 to 16 carry result bits 11 down to 0. In oscillator-clocked mode the completion flag is position 1, and each later `sclk` falling edge moves one position forward.
- R6: While selected, `dout` changes only after an `sclk` falling edge or the completion flag. Every falling edge after position 16 drives 0.
- R7: The first conversion after reset uses channel 0, and each select cycle flips the channel. An extra select cycle without a conversion therefore leaves two conversions on the same channel. `chan_sel` holds steady while the block is selected.
- R8: Raising `cs_n` before the result is complete aborts the conversion. The trial code is cleared, and the next conversion runs normally on the next channel.
- R9: Bits are tried from MSB to LSB. Each trial bit is set, then cleared when `cmp_high`=1 (DAC level above the held sample). The final `sar_code` is the largest code not above the sample. In host-clocked mode the decision for bit k falls on the same `sclk` edge that drives bit k out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high means power down |
| sclk | input | 1 | Host serial clock, sampled on `clk` |
| osc_tick | input | 1 | One-cycle enable from the conversion oscillator |
| cmp_high | input | 1 | Comparator: DAC trial level above held sample |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the serial data pad |
| chan_sel | output | 1 | Input multiplexer select (0 or 1) |
| track | output | 1 | Track/hold in track when 1 |
| sar_code | output | 12 | Trial code for the capacitive DAC |
| pwr_down | output | 1 | Block is powered down |

## Verification
The bench attacks the edge that ends tracking. A design that samples on the first host edge in host-clocked mode, or on the second edge in oscillator-clocked mode, drops `track` one edge early or late. It also puts the frame one position off. The bench checks the completion flag one tick before and one tick after the twelfth decision, to catch an off-by-one decision counter. It checks the trailing zeros past the LSB, and checks `dout` in mid-pulse to catch data that moves on the rising edge. Aborts in both modes are followed by a clean conversion, and an extra empty select cycle must repeat a channel, so a design that keeps stale code bits or flips the channel per conversion rather than per select cycle gives a wrong frame.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_TRACK,
    ST_EXT,
    ST_INT,
    ST_READ
  } sadc_state_t;
endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= RST_VAL;
    else        sig_q <= sig;
  end

  assign fall = sig_q & ~sig;
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar #(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           load,
  input  logic           step,
  input  logic           cmp_high,
  output logic [RES-1:0] code,
  output logic           last
);
  localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  logic [IDX_W-1:0] idx;

  function automatic logic [RES-1:0] sar_next(input logic [RES-1:0] c,
                                               input logic [IDX_W-1:0] i,
                                               input logic hi);
    logic [RES-1:0] r;
    r = c;
    if (hi) r[i] = 1'b0;
    if (i != '0) r[i - 1'b1] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      idx  <= IDX_W'(RES - 1);
    end else if (clr) begin
      code <= '0;
      idx  <= IDX_W'(RES - 1);
    end else if (load) begin
      code <= MSB_ONLY;
      idx  <= IDX_W'(RES - 1);
    end else if (step) begin
      code <= sar_next(code, idx, cmp_high);
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

  assign last = step && !clr && !load && (idx == '0);

  assert_load_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (code == MSB_ONLY));

  assert_keep_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load && !cmp_high) |=> ($countones(code) >= $countones($past(code))));
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame #(
  parameter int RES  = 12,
  parameter int LEAD = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  adv,
  input  logic                  set_eoc,
  input  logic                  chid,
  input  logic [RES-1:0]        code,
  output logic [$clog2(LEAD+RES+3)-1:0] pos,
  output logic                  bit_out
);
  localparam int FRAME = LEAD + 1 + RES;
  localparam int POS_W = $clog2(LEAD + RES + 3);
  localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME + 1);

  function automatic logic frame_bit(input logic [POS_W-1:0] p,
                                     input logic ch,
                                     input logic [RES-1:0] c);
    int pi;
    pi = int'(p);
    if (pi == 0 || pi > FRAME) return 1'b0;
    if (pi <= LEAD)            return 1'b1;
    if (pi == LEAD + 1)        return ch;
    return c[FRAME - pi];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos <= '0;
    else if (clr)       pos <= '0;
    else if (set_eoc)   pos <= POS_W'(1);
    else if (adv && pos != POS_END) pos <= pos + 1'b1;
  end

  assign bit_out = frame_bit(pos, chid, code);

  assert_trail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == POS_END) |-> !bit_out);
endmodule

// File: rtl/sar_adc_serial.sv
module sar_adc_serial #(
  parameter int RES  = 12,
  parameter int LEAD = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           osc_tick,
  input  logic           cmp_high,
  output logic           dout,
  output logic           dout_oe,
  output logic           chan_sel,
  output logic           track,
  output logic [RES-1:0] sar_code,
  output logic           pwr_down
);
  import sar_adc_pkg::*;

  localparam int FRAME = LEAD + 1 + RES;
  localparam int POS_W = $clog2(LEAD + RES + 3);
  localparam int CNT_W = $clog2(RES + 1);

  sadc_state_t      state;
  logic             ext_mode, chid, next_ch;
  logic             cs_fall, sclk_fall;
  logic [POS_W-1:0] pos;
  logic             frm_bit, sar_last;
  logic             frm_adv, sar_load, sar_step, conv_done;
  logic [CNT_W-1:0] tick_cnt;

  sadc_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .sig(cs_n), .fall(cs_fall));

  sadc_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .sig(sclk), .fall(sclk_fall));

  // named control events
  assign frm_adv   = !cs_n && sclk_fall &&
                     ((state == ST_TRACK && ext_mode) || state == ST_EXT || state == ST_READ);
  assign sar_load  = !cs_n && sclk_fall && state == ST_TRACK &&
                     (!ext_mode || pos == POS_W'(1));
  assign sar_step  = !cs_n &&
                     ((state == ST_EXT && sclk_fall &&
                       pos >= POS_W'(LEAD + 1) && pos < POS_W'(FRAME)) ||
                      (state == ST_INT && osc_tick));
  assign conv_done = !cs_n && state == ST_INT && sar_last;

  sadc_sar #(.RES(RES)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(cs_n), .load(sar_load), .step(sar_step),
    .cmp_high(cmp_high), .code(sar_code), .last(sar_last));

  sadc_frame #(.RES(RES), .LEAD(LEAD)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(cs_n), .adv(frm_adv), .set_eoc(conv_done),
    .chid(chid), .code(sar_code), .pos(pos), .bit_out(frm_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      ext_mode <= 1'b0;
      chid     <= 1'b0;
      next_ch  <= 1'b0;
    end else if (cs_n) begin
      state <= ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: if (cs_fall) begin
          state    <= ST_TRACK;
          ext_mode <= ~sclk;
          chid     <= next_ch;
          next_ch  <= ~next_ch;
        end
        ST_TRACK: if (sar_load) state <= ext_mode ? ST_EXT : ST_INT;
        ST_INT:   if (conv_done) state <= ST_READ;
        default:  state <= state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tick_cnt <= '0;
    else if (sar_load || cs_n)       tick_cnt <= '0;
    else if (state == ST_INT && sar_step) tick_cnt <= tick_cnt + 1'b1;
  end

  assign dout_oe  = (state != ST_OFF);
  assign pwr_down = (state == ST_OFF);
  assign track    = (state == ST_TRACK);
  assign chan_sel = chid;
  assign dout     = dout_oe & frm_bit;

  assert_off_when_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (pwr_down && !dout_oe && !dout && !track));

  assert_int_first_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (track && sclk_fall && !ext_mode && !cs_n) |=> (!track && !dout));

  assert_ext_keep_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (track && sclk_fall && ext_mode && !cs_n && pos == '0) |=> track);

  assert_eoc_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> dout);

  assert_decision_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INT) |-> (tick_cnt < CNT_W'(RES)));

  assert_dout_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && !cs_n && !sclk_fall && !conv_done) |=> $stable(dout));

  assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && !cs_n) |=> $stable(chan_sel));
endmodule

// File: tb/sar_adc_serial_tb.sv
module sar_adc_serial_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cs_n, sclk, osc_tick, cmp_high;
  logic dout, dout_oe, chan_sel, track, pwr_down;
  logic [11:0] sar_code;
  logic [11:0] vin0, vin1;
  int n_tests = 0, n_fail = 0;
  int ch_cnt = 0;

  assign cmp_high = (sar_code > (chan_sel ? vin1 : vin0));

  sar_adc_serial u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .osc_tick(osc_tick),
    .cmp_high(cmp_high), .dout(dout), .dout_oe(dout_oe), .chan_sel(chan_sel),
    .track(track), .sar_code(sar_code), .pwr_down(pwr_down));

  // bit 12: 1 = oscillator-clocked mode; bits 11:0 input value on channel 0
  localparam logic [12:0] VEC [0:5] = '{
    {1'b0, 12'hABC}, {1'b0, 12'h000}, {1'b1, 12'hFFF},
    {1'b1, 12'h555}, {1'b0, 12'h800}, {1'b1, 12'h7FF}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sclk pulse; returns dout while high and after the falling edge
  task automatic pulse(output logic mid, output logic after);
    sclk = 1'b1; wclk(3); mid = dout;
    sclk = 1'b0; wclk(3); after = dout;
  endtask

  task automatic select(input logic lvl);
    sclk = lvl; wclk(2); cs_n = 1'b0; wclk(3);
  endtask

  task automatic deselect();
    cs_n = 1'b1; wclk(3);
    check("R1 oe off", {31'd0, dout_oe}, 32'd0);
    check("R1 pwr_down", {31'd0, pwr_down}, 32'd1);
  endtask

  task automatic set_inputs(input logic [11:0] v);
    vin0 = v; vin1 = ~v;
  endtask

  task automatic run_ext(input logic exp_ch, output logic [15:0] frame);
    logic mid, aft, prev;
    select(1'b0);
    check("R2 ext track", {31'd0, track}, 32'd1);
    check("R2 ext dout idle", {31'd0, dout}, 32'd0);
    check("R7 chan_sel", {31'd0, chan_sel}, {31'd0, exp_ch});
    prev = dout;
    for (int i = 0; i < 16; i++) begin
      pulse(mid, aft);
      frame[15-i] = aft;
      check("R6 stable in high phase", {31'd0, mid}, {31'd0, prev});
      prev = aft;
      if (i == 0) check("R3 track after 1st fall", {31'd0, track}, 32'd1);
      if (i == 1) check("R3 track after 2nd fall", {31'd0, track}, 32'd0);
      if (i == 1) check("R3 trial code loaded", {20'd0, sar_code}, 32'h800);
    end
    for (int i = 0; i < 2; i++) begin
      pulse(mid, aft);
      check("R6 trailing zero", {31'd0, aft}, 32'd0);
    end
  endtask

  task automatic run_int(input logic exp_ch, output logic [15:0] frame);
    logic mid, aft;
    select(1'b1);
    check("R2 int track", {31'd0, track}, 32'd1);
    check("R7 chan_sel", {31'd0, chan_sel}, {31'd0, exp_ch});
    sclk = 1'b0; wclk(3);
    check("R2 int track ends on 1st fall", {31'd0, track}, 32'd0);
    for (int t = 0; t < 14; t++) begin
      osc_tick = 1'b1; wclk(1); osc_tick = 1'b0; wclk(2);
      if (t == 10) check("R4 no flag after 11 ticks", {31'd0, dout}, 32'd0);
      if (t == 11) check("R4 flag after 12 ticks", {31'd0, dout}, 32'd1);
    end
    frame[15] = dout;
    for (int i = 1; i < 16; i++) begin
      pulse(mid, aft);
      frame[15-i] = aft;
    end
    pulse(mid, aft);
    check("R6 trailing zero int", {31'd0, aft}, 32'd0);
  endtask

  task automatic convert(input logic int_mode, input logic [11:0] v);
    logic [15:0] fr;
    logic ech;
    logic [11:0] ev;
    ech = ch_cnt[0]; ch_cnt++;
    ev = ech ? ~v : v;
    set_inputs(v);
    if (int_mode) run_int(ech, fr); else run_ext(ech, fr);
    check("R5 frame", {16'd0, fr}, {16'd0, 3'b111, ech, ev});
    check("R9 final code", {20'd0, sar_code}, {20'd0, ev});
    deselect();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic mid, aft;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; osc_tick = 1'b0; vin0 = '0; vin1 = '0;
    wclk(3); rst_n = 1'b1; wclk(2);
    // R1 reset state
    check("R1 reset pwr_down", {31'd0, pwr_down}, 32'd1);
    check("R1 reset oe", {31'd0, dout_oe}, 32'd0);
    check("R1 reset track", {31'd0, track}, 32'd0);
    check("R1 reset code", {20'd0, sar_code}, 32'd0);
    check("R1 reset dout", {31'd0, dout}, 32'd0);

    for (int k = 0; k < 6; k++) convert(VEC[k][12], VEC[k][11:0]);

    // R8 abort in host-clocked mode (channel 0)
    set_inputs(12'h3C3);
    select(1'b0); ch_cnt++;
    for (int i = 0; i < 8; i++) pulse(mid, aft);
    deselect();
    check("R8 code cleared after abort", {20'd0, sar_code}, 32'd0);
    // extra empty select cycle (channel 1) -> next conversion on channel 0 again
    cs_n = 1'b0; wclk(3); ch_cnt++;
    check("R7 empty cycle chan", {31'd0, chan_sel}, 32'd1);
    deselect();
    check("R7 repeat channel expected 0", ch_cnt[0], 32'd0);
    convert(1'b0, 12'h3C3);

    // R8 abort in oscillator-clocked mode (channel 1)
    select(1'b1); ch_cnt++;
    sclk = 1'b0; wclk(3);
    for (int t = 0; t < 6; t++) begin
      osc_tick = 1'b1; wclk(1); osc_tick = 1'b0; wclk(2);
    end
    deselect();
    check("R8 code cleared after int abort", {20'd0, sar_code}, 32'd0);
    convert(1'b1, 12'h001);
    convert(1'b0, 12'hFFE);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule